// File: doc/BRIEF.md
# Caption Clock Run-in and Start Detector

This block sits behind the data-slicer comparator of a video front end and looks for caption data on one scan line. The line-selection logic holds `line_en` high for the whole of the chosen line. While it is high, the block waits a programmable delay and then opens a fixed-length window. In that window it counts rising edges of the one-bit sliced stream and measures their spacing in reference clocks. The sliced stream is observed through a sampling strobe derived by dividing the reference clock.

A window that holds enough edges confirms the run-in burst. Only then does the block sample the stream at bit centres, timed from the last run-in edge, and look for the start pattern. A match raises a one-cycle interrupt pulse and sets a sticky flag. In the same cycle the measured period is latched into an eight-bit read-only detect register. On every other line the sliced input has no effect.

Top module: `cc_runin_detect`

## Requirements
- R1: After reset `det_reg` is 0x00, `irq_pulse` is 0 and `irq_flag` is 0.
- R2: While `line_en` is low, activity on `slice_in` produces no interrupt and leaves `det_reg` unchanged.
- R3: The run-in is confirmed only if the edge window contains at least MIN_EDGES (default 6) rising edges. With fewer edges there is no interrupt and `det_reg` keeps its previous value. The window opens `win_delay` reference clocks after `line_en` rises and lasts WIN_LEN clocks.
- R4: On a detection, `det_reg[7:3]` holds the number of reference clocks between the last two run-in rising edges, so a period of 20 clocks reads 0xA0.
- R5: A period of more than 31 clocks is reported as 31 (`det_reg` = 0xF8).
- R6: Detection needs the start pattern 0,0,1 (oldest first) in three consecutive bit-centre samples taken after the window closes. The first sample is half a period after the last run-in edge, and the samples repeat every period. If the line stays low after the run-in, nothing is raised.
- R7: `irq_pulse` is high for exactly one cycle per detection. `irq_flag` goes high with it and stays high until `irq_clr` is asserted.
- R8: `det_reg[2:0]` always reads 0.
- R9: If `line_en` falls before the start pattern completes, the search is abandoned and no interrupt follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_en | input | 1 | High during the selected scan line |
| slice_in | input | 1 | Sliced video from the comparator |
| win_delay | input | DLY_W | Reference clocks from line start to window open |
| irq_clr | input | 1 | Write-one-to-clear for the sticky flag |
| irq_pulse | output | 1 | One-cycle detection pulse |
| irq_flag | output | 1 | Sticky detection flag |
| det_reg | output | PW+TEST_W | Measured period in [7:3], zeros in [2:0] |

## Verification
The hardest condition to reach is a window that closes after the last run-in edge but before the start bit's rising edge. If the start bit edge fell inside the window, it would count as one more run-in edge and reset the phase. The bench places every burst so that its last edge lands one period before the window closes, computed from `win_delay` and WIN_LEN. The run-in pulses use a quarter-period high time, so the bit-centre samples fall well inside the low stretch and then inside the start bit.

// File: rtl/cc_rid_pkg.sv
package cc_rid_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_DELAY,
      S_WIN,
      S_HUNT,
      S_DONE
   } rid_state_e;

   localparam logic [2:0] START_PAT = 3'b001;
endpackage

// File: rtl/cc_rid_sampler.sv
module cc_rid_sampler #(
   parameter int DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_en,
   input  logic slice_in,
   output logic s_lvl,
   output logic edge_evt
);
   localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

   logic [1:0] sync;
   logic       strobe;

   generate
      if (DIV == 1) begin : g_nodiv
         assign strobe = 1'b1;
      end else begin : g_div
         logic [DW-1:0] dc;
         always_ff @(posedge clk) begin
            if (!rst_n || !line_en || dc == DW'(DIV - 1))
               dc <= '0;
            else
               dc <= dc + 1'b1;
         end
         assign strobe = (dc == '0);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync  <= '0;
         s_lvl <= 1'b0;
      end else begin
         sync <= {sync[0], slice_in};
         if (strobe) s_lvl <= sync[1];
      end
   end

   assign edge_evt = strobe & sync[1] & ~s_lvl;

   // R3
   edge_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      edge_evt |=> s_lvl);
endmodule

// File: rtl/cc_rid_window.sv
module cc_rid_window
   import cc_rid_pkg::*;
#(
   parameter int DLY_W     = 8,
   parameter int WIN_LEN   = 200,
   parameter int MIN_EDGES = 6,
   parameter int PW        = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_en,
   input  logic             edge_evt,
   input  logic             match,
   input  logic [DLY_W-1:0] win_delay,
   output rid_state_e       st,
   output logic [PW-1:0]    per,
   output logic [PW-1:0]    gap
);
   localparam int WB = $clog2(WIN_LEN) + 1;
   localparam int CW = (DLY_W > WB) ? DLY_W : WB;
   localparam int EW = $clog2(MIN_EDGES + 1);
   localparam logic [PW-1:0] SAT = '1;

   logic [CW-1:0] cnt;
   logic [EW-1:0] ecnt;
   logic          line_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         cnt    <= '0;
         ecnt   <= '0;
         per    <= '0;
         gap    <= '0;
         line_q <= 1'b0;
      end else begin
         line_q <= line_en;
         if (!line_en) begin
            st <= S_IDLE;
         end else if (!line_q) begin
            st   <= S_DELAY;
            cnt  <= '0;
            ecnt <= '0;
            gap  <= '0;
         end else begin
            unique case (st)
               S_DELAY: begin
                  if (cnt == CW'(win_delay)) begin
                     st  <= S_WIN;
                     cnt <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               S_WIN: begin
                  cnt <= cnt + 1'b1;
                  if (edge_evt) begin
                     gap <= PW'(1);
                     if (ecnt != '0) per <= gap;
                     if (ecnt != EW'(MIN_EDGES)) ecnt <= ecnt + 1'b1;
                  end else if (gap != SAT) begin
                     gap <= gap + 1'b1;
                  end
                  if (cnt == CW'(WIN_LEN - 1))
                     st <= (ecnt == EW'(MIN_EDGES)) ? S_HUNT : S_DONE;
               end
               S_HUNT:  if (match) st <= S_DONE;
               default: ;
            endcase
         end
      end
   end

   // R2
   idle_off_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !line_en |=> st == S_IDLE);
   // R3
   enough_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_HUNT && $past(st) == S_WIN) |-> $past(ecnt) == EW'(MIN_EDGES));
endmodule

// File: rtl/cc_rid_hunt.sv
module cc_rid_hunt
   import cc_rid_pkg::*;
#(
   parameter int PW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  rid_state_e    st,
   input  logic          edge_evt,
   input  logic          s_lvl,
   input  logic [PW-1:0] per,
   input  logic [PW-1:0] gap,
   output logic          match
);
   logic [PW-1:0] dn;
   logic [2:0]    sh;
   logic [2:0]    sh_nx;

   assign sh_nx = {sh[1:0], s_lvl};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dn    <= '0;
         sh    <= 3'b111;
         match <= 1'b0;
      end else begin
         match <= 1'b0;
         if (st != S_WIN && st != S_HUNT) begin
            dn <= '0;
            sh <= 3'b111;
         end else if (st == S_WIN && edge_evt) begin
            dn <= gap >> 1;
            sh <= 3'b111;
         end else if (dn == '0) begin
            dn <= per - 1'b1;
            sh <= sh_nx;
            if (st == S_HUNT && sh_nx == START_PAT) match <= 1'b1;
         end else begin
            dn <= dn - 1'b1;
         end
      end
   end

   // R6
   match_in_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match |-> $past(st) == S_HUNT);
   // R6
   match_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match |-> sh == START_PAT);
endmodule

// File: rtl/cc_runin_detect.sv
module cc_runin_detect
   import cc_rid_pkg::*;
#(
   parameter int DIV       = 2,
   parameter int DLY_W     = 8,
   parameter int WIN_LEN   = 200,
   parameter int MIN_EDGES = 6,
   parameter int PW        = 5,
   parameter int TEST_W    = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   line_en,
   input  logic                   slice_in,
   input  logic [DLY_W-1:0]       win_delay,
   input  logic                   irq_clr,
   output logic                   irq_pulse,
   output logic                   irq_flag,
   output logic [PW+TEST_W-1:0]   det_reg
);
   generate
      if (DIV < 1) begin : g_bad_div
         $error("DIV must be at least 1");
      end
      if (MIN_EDGES < 2) begin : g_bad_edges
         $error("MIN_EDGES must be at least 2");
      end
      if (PW < 2) begin : g_bad_pw
         $error("PW must be at least 2");
      end
      if (WIN_LEN < 4) begin : g_bad_win
         $error("WIN_LEN must be at least 4");
      end
   endgenerate

   logic          s_lvl;
   logic          edge_evt;
   logic          match;
   rid_state_e    st;
   logic [PW-1:0] per;
   logic [PW-1:0] gap;
   logic [PW-1:0] per_q;

   cc_rid_sampler #(.DIV(DIV)) u_smp (
      .clk(clk), .rst_n(rst_n), .line_en(line_en), .slice_in(slice_in),
      .s_lvl(s_lvl), .edge_evt(edge_evt)
   );

   cc_rid_window #(.DLY_W(DLY_W), .WIN_LEN(WIN_LEN), .MIN_EDGES(MIN_EDGES), .PW(PW)) u_win (
      .clk(clk), .rst_n(rst_n), .line_en(line_en), .edge_evt(edge_evt),
      .match(match), .win_delay(win_delay), .st(st), .per(per), .gap(gap)
   );

   cc_rid_hunt #(.PW(PW)) u_hunt (
      .clk(clk), .rst_n(rst_n), .st(st), .edge_evt(edge_evt),
      .s_lvl(s_lvl), .per(per), .gap(gap), .match(match)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         per_q     <= '0;
         irq_pulse <= 1'b0;
         irq_flag  <= 1'b0;
      end else begin
         irq_pulse <= match;
         irq_flag  <= match | (irq_flag & ~irq_clr);
         if (match) per_q <= per;
      end
   end

   assign det_reg = {per_q, {TEST_W{1'b0}}};

   // R7
   irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |=> !irq_pulse);
   // R7
   irq_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> irq_flag);
   // R7
   irq_flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_flag) |-> $past(irq_clr));
   // R4
   reg_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(per_q) |-> irq_pulse);
endmodule

// File: tb/cc_runin_detect_bench.sv
module cc_runin_detect_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_en = 1'b0;
   logic       slice_in = 1'b0;
   logic [7:0] win_delay = 8'd20;
   logic       irq_clr = 1'b0;
   logic       irq_pulse;
   logic       irq_flag;
   logic [7:0] det_reg;

   int checks = 0;
   int failures = 0;
   int pulses = 0;
   int run_len = 0;
   int max_run = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   cc_runin_detect u_cc_runin_detect (
      .clk(clk), .rst_n(rst_n), .line_en(line_en), .slice_in(slice_in),
      .win_delay(win_delay), .irq_clr(irq_clr), .irq_pulse(irq_pulse),
      .irq_flag(irq_flag), .det_reg(det_reg)
   );

   always @(negedge clk) begin
      if (irq_pulse) begin
         pulses  <= pulses + 1;
         run_len <= run_len + 1;
         if (run_len + 1 > max_run) max_run <= run_len + 1;
      end else begin
         run_len <= 0;
      end
   end

   // columns: period, run-in cycles, start bit present, expected pulses, expected det_reg
   localparam int NV = 6;
   localparam int TBL[NV][5] = '{
      '{20, 7, 1, 1, 8'hA0},   // R4
      '{24, 8, 1, 1, 8'hC0},   // R4
      '{32, 6, 1, 1, 8'hF8},   // R5 saturation, R3 exactly six edges
      '{20, 5, 1, 0, 8'hF8},   // R3 too few edges, register kept
      '{16, 9, 1, 1, 8'h80},   // R4
      '{20, 7, 0, 0, 8'h80}    // R6 no start bit
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // window open is about win_delay+1 clocks after line start and lasts 200
   task automatic run_line(input int p, input int n, input bit st_ok,
                           input int drop_k, input bit en);
      int s;
      int total;
      s = 222 - p - (n - 1) * p;
      total = s + (n + 3) * p + 20;
      pulses = 0;
      max_run = 0;
      for (int k = 0; k < total; k++) begin
         int rel;
         @(negedge clk);
         line_en = en && (drop_k == 0 || k < drop_k);
         rel = k - s;
         if (rel >= 0 && rel < n * p)
            slice_in = (rel % p) < (p / 4);
         else
            slice_in = st_ok && rel >= (n + 1) * p;
      end
      @(negedge clk);
      line_en = 1'b0;
      slice_in = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic clear_flag();
      @(negedge clk);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(det_reg == 8'h00, "R1 det_reg", det_reg, 0);
      check(irq_pulse == 1'b0, "R1 irq_pulse", irq_pulse, 0);
      check(irq_flag == 1'b0, "R1 irq_flag", irq_flag, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         run_line(TBL[v][0], TBL[v][1], TBL[v][2] != 0, 0, 1'b1);
         check(pulses == TBL[v][3], "R6 pulse count", pulses, TBL[v][3]);
         check(det_reg == 8'(TBL[v][4]), "R4 det_reg", det_reg, TBL[v][4]);
         check(det_reg[2:0] == 3'b000, "R8 low bits", det_reg[2:0], 0);
         check(irq_flag == (TBL[v][3] != 0), "R7 sticky flag", irq_flag, TBL[v][3]);
         if (TBL[v][3] != 0)
            check(max_run == 1, "R7 pulse width", max_run, 1);
         clear_flag();
         check(irq_flag == 1'b0, "R7 flag cleared", irq_flag, 0);
      end

      // R2: a full burst with start bit while the line is not selected
      run_line(20, 7, 1'b1, 0, 1'b0);
      check(pulses == 0, "R2 ignored pulses", pulses, 0);
      check(det_reg == 8'h80, "R2 det_reg kept", det_reg, 8'h80);
      check(irq_flag == 1'b0, "R2 flag", irq_flag, 0);

      // R9: line drops during the bit-centre search, before the start bit
      run_line(20, 7, 1'b1, (222 - 20 - 120) + 7 * 20 + 15, 1'b1);
      check(pulses == 0, "R9 abort pulses", pulses, 0);
      check(det_reg == 8'h80, "R9 det_reg kept", det_reg, 8'h80);

      // R7: flag persists without clear across idle time
      run_line(20, 7, 1'b1, 0, 1'b1);
      repeat (50) @(negedge clk);
      check(irq_flag == 1'b1, "R7 flag persists", irq_flag, 1);
      check(det_reg == 8'hA0, "R4 det_reg again", det_reg, 8'hA0);
      clear_flag();
      check(irq_flag == 1'b0, "R7 flag cleared", irq_flag, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule